// File: doc/BRIEF.md
# Quad SPI PIO transfer sequencer

This block runs one half-duplex transfer to a serial flash over one, two or four data lines. Software first sets up a configuration word: direction, lane-width code, which of two chip selects to use, and whether the transfer is a fragment of a longer frame. Writing a nonzero byte count then launches the transfer. Bytes to send come from an external transmit FIFO through a pop handshake. Received bytes leave through a push strobe toward an external receive FIFO.

The serial clock is derived from the core clock at one quarter of its rate. It idles low and data is captured on its rising edge (mode 0). When the last byte completes, a done status bit is set and the interrupt line rises. Chip select is then released, unless the transfer was marked as a fragment; in that case it stays asserted so that the next transfer continues the same frame. Register access is a single-cycle valid/ready port that is always ready.

Top module: `qspi_pio_seq`

## Requirements
- R1: Register address 0 holds the configuration: bit 0 direction (1 = write to flash, 0 = read), bits 3:1 lane-width code, bit 4 chip-select choice, bit 8 fragment flag. It reads back with all other bits zero.
- R2: A write to address 1 while idle starts a transfer of wdata[15:0] bytes. A count of zero starts nothing: done is set at once and no serial clock is produced.
- R3: Width code 1 uses one lane (out on io[0], in on io[1]). Code 2 uses two lanes (io[1:0]). Code 3 uses four lanes (io[3:0]). Any other code falls back to one lane. Each byte moves most significant group first.
- R4: SCK is low whenever no beat is in progress. Each beat lasts four core cycles, two low then two high. Output data holds steady while SCK is high.
- R5: In a write transfer, each byte is taken from tx_data in the cycle where tx_pop is high. In a read transfer, each received byte appears on rx_data with a one-cycle rx_push pulse.
- R6: A read transfer enables no output lane. A write transfer produces no rx_push. A write transfer enables exactly the lanes of its width.
- R7: Status address 2 bit 16 (done) and irq rise when the final byte ends. Writing 1 to status bit 16, or starting a transfer, clears done. A done set and a clear in the same cycle leave done set.
- R8: Configuration bit 4 selects cs_n[1] when 1 and cs_n[0] when 0, and the other line stays high. After the final byte, chip select is released if the fragment flag was clear and held low if it was set.
- R9: A count write while busy is ignored. It sets sticky status bit 1, which a write of 1 to status bit 1 clears. Status bit 0 reads busy.
- R10: In reset, cs_n is 2'b11, SCK is low, no lane is enabled, irq is low and status reads zero.
- R11: In a write transfer with tx_valid low, SCK stays low and chip select stays asserted until a byte is available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, four times the serial rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register address (0 config, 1 count, 2 status) |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Always high; every access completes in its cycle |
| reg_rdata | output | 32 | Read data for reg_addr |
| irq | output | 1 | Done interrupt, follows status bit 16 |
| tx_data | input | 8 | Head byte of the transmit FIFO |
| tx_valid | input | 1 | Transmit FIFO not empty |
| tx_pop | output | 1 | Takes tx_data this cycle |
| rx_data | output | 8 | Received byte |
| rx_push | output | 1 | rx_data valid for one cycle |
| sck | output | 1 | Serial clock |
| cs_n | output | 2 | Active-low chip selects |
| io_out | output | 4 | Lane output data |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input data |

## Verification
The interesting overlap is a count write that arrives on the very edge where the final beat of a transfer ends, so that the same edge clears busy and sees a start request. The bench counts rising edges of SCK until the last one of a single-byte quad write. It then waits two core cycles into the high half of that beat and drives the count write so that it is sampled on the completing edge. The result is judged at the ports. Status must show done set, busy clear and the ignored-start flag set, and no further SCK pulse may follow. That shows the busy check used the registered state of the ending transfer.

// File: rtl/qspi_pio_seq.sv
module qspi_pio_seq #(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_valid,
  input  logic        reg_write,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic        reg_ready,
  output logic [31:0] reg_rdata,
  output logic        irq,
  input  logic [7:0]  tx_data,
  input  logic        tx_valid,
  output logic        tx_pop,
  output logic [7:0]  rx_data,
  output logic        rx_push,
  output logic        sck,
  output logic [1:0]  cs_n,
  output logic [3:0]  io_out,
  output logic [3:0]  io_oe,
  input  logic [3:0]  io_in
);

  logic             cfg_dir, cfg_cs, cfg_frag;
  logic [2:0]       cfg_mode;
  logic             act_dir, act_cs, act_frag;
  logic [1:0]       act_w;
  logic             busy, have, cs_on, done, ovf;
  logic [1:0]       phase;
  logic [2:0]       beat;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       sreg, shift_in, shift_out, rx_q;
  logic             rx_push_q;

  function automatic logic [1:0] lanes_of(input logic [2:0] code);
    case (code)
      3'd2:    return 2'd1;
      3'd3:    return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

  wire wr       = reg_valid & reg_write;
  wire wr_cfg   = wr && reg_addr == 2'd0;
  wire wr_cnt   = wr && reg_addr == 2'd1;
  wire wr_st    = wr && reg_addr == 2'd2;
  wire start    = wr_cnt & ~busy;
  wire cnt_zero = reg_wdata[CNT_W-1:0] == '0;
  wire last_beat = beat == (act_w == 2'd2 ? 3'd1 : act_w == 2'd1 ? 3'd3 : 3'd7);

  logic unused_bits;
  assign unused_bits = ^reg_wdata;

  always_comb begin
    case (act_w)
      2'd2:    begin shift_in = {sreg[3:0], io_in};      shift_out = {sreg[3:0], 4'b0}; end
      2'd1:    begin shift_in = {sreg[5:0], io_in[1:0]}; shift_out = {sreg[5:0], 2'b0}; end
      default: begin shift_in = {sreg[6:0], io_in[1]};   shift_out = {sreg[6:0], 1'b0}; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_dir <= 1'b0; cfg_cs <= 1'b0; cfg_frag <= 1'b0; cfg_mode <= '0;
      act_dir <= 1'b0; act_cs <= 1'b0; act_frag <= 1'b0; act_w <= '0;
      busy <= 1'b0; have <= 1'b0; cs_on <= 1'b0; done <= 1'b0; ovf <= 1'b0;
      phase <= '0; beat <= '0; cnt <= '0; sreg <= '0; rx_q <= '0; rx_push_q <= 1'b0;
    end else begin
      rx_push_q <= 1'b0;
      if (wr_cfg) begin
        cfg_dir  <= reg_wdata[0];
        cfg_mode <= reg_wdata[3:1];
        cfg_cs   <= reg_wdata[4];
        cfg_frag <= reg_wdata[8];
      end
      if (wr_st && reg_wdata[16]) done <= 1'b0;
      if (wr_st && reg_wdata[1])  ovf  <= 1'b0;
      if (wr_cnt && busy)         ovf  <= 1'b1;
      if (start) begin
        done <= cnt_zero;
        if (!cnt_zero) begin
          busy     <= 1'b1;
          cnt      <= reg_wdata[CNT_W-1:0];
          act_dir  <= cfg_dir;
          act_w    <= lanes_of(cfg_mode);
          act_cs   <= cfg_cs;
          act_frag <= cfg_frag;
          cs_on    <= 1'b1;
          have     <= 1'b0;
          phase    <= '0;
          beat     <= '0;
        end
      end else if (busy) begin
        if (!have) begin
          if (!act_dir) begin
            have <= 1'b1;
            sreg <= '0;
          end else if (tx_valid) begin
            have <= 1'b1;
            sreg <= tx_data;
          end
        end else begin
          phase <= phase + 2'd1;
          if (phase == 2'd1 && !act_dir) sreg <= shift_in;
          if (phase == 2'd3) begin
            if (act_dir) sreg <= shift_out;
            if (last_beat) begin
              beat <= '0;
              have <= 1'b0;
              cnt  <= cnt - CNT_W'(1);
              if (!act_dir) begin
                rx_push_q <= 1'b1;
                rx_q      <= sreg;
              end
              if (cnt == CNT_W'(1)) begin
                busy  <= 1'b0;
                done  <= 1'b1;
                cs_on <= act_frag;
              end
            end else begin
              beat <= beat + 3'd1;
            end
          end
        end
      end
    end
  end

  assign reg_ready = 1'b1;
  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {23'b0, cfg_frag, 3'b0, cfg_cs, cfg_mode, cfg_dir};
      2'd1:    reg_rdata = 32'(cnt);
      2'd2:    reg_rdata = {15'b0, done, 14'b0, ovf, busy};
      default: reg_rdata = '0;
    endcase
  end

  assign irq     = done;
  assign tx_pop  = busy & ~have & act_dir & tx_valid;
  assign rx_data = rx_q;
  assign rx_push = rx_push_q;
  assign sck     = busy & have & phase[1];
  assign cs_n    = ~({act_cs, ~act_cs} & {2{cs_on}});
  assign io_oe   = (busy & act_dir) ? (act_w == 2'd2 ? 4'b1111 : act_w == 2'd1 ? 4'b0011 : 4'b0001) : 4'b0000;
  assign io_out  = io_oe & (act_w == 2'd2 ? sreg[7:4] : act_w == 2'd1 ? {2'b0, sreg[7:6]} : {3'b0, sreg[7]});

endmodule

// File: rtl/qspi_pio_seq_chk.sv
module qspi_pio_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic [1:0] cs_n,
  input logic [3:0] io_out,
  input logic [3:0] io_oe,
  input logic       busy,
  input logic       act_dir,
  input logic       done,
  input logic       ovf,
  input logic       reg_valid,
  input logic       reg_write,
  input logic [1:0] reg_addr
);

  p_one_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_read_drives_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !act_dir |-> io_oe == 4'b0000);

  p_sck_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sck && $past(sck) |-> $stable(io_out));

  p_end_sets_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_busy_start_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid && reg_write && reg_addr == 2'd1 && busy |=> ovf);

endmodule

bind qspi_pio_seq qspi_pio_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
  .busy(busy), .act_dir(act_dir), .done(done), .ovf(ovf),
  .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr)
);

// File: tb/sim_qspi_pio_seq.sv
module sim_qspi_pio_seq;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        reg_ready, irq, tx_pop, rx_push, sck;
  logic [31:0] reg_rdata;
  logic [7:0]  tx_data, rx_data;
  logic        tx_valid;
  logic [1:0]  cs_n;
  logic [3:0]  io_out, io_oe, io_in;

  qspi_pio_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_ready(reg_ready), .reg_rdata(reg_rdata),
    .irq(irq), .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop),
    .rx_data(rx_data), .rx_push(rx_push), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // stimulus: {dir, mode[2:0], frag, cs, count[7:0], seed[7:0]}
  localparam logic [21:0] VEC [9] = '{
    {1'b1, 3'd1, 1'b0, 1'b0, 8'd3, 8'hA5},
    {1'b1, 3'd2, 1'b0, 1'b1, 8'd2, 8'h3C},
    {1'b1, 3'd3, 1'b0, 1'b0, 8'd4, 8'h96},
    {1'b0, 3'd1, 1'b0, 1'b0, 8'd2, 8'hC3},
    {1'b0, 3'd2, 1'b0, 1'b1, 8'd3, 8'h5A},
    {1'b0, 3'd3, 1'b0, 1'b0, 8'd4, 8'hE1},
    {1'b1, 3'd7, 1'b0, 1'b0, 8'd1, 8'h81},
    {1'b0, 3'd3, 1'b1, 1'b1, 8'd2, 8'h4D},
    {1'b1, 3'd3, 1'b0, 1'b1, 8'd1, 8'h77}
  };

  // serial-side model and FIFO models
  int bw = 1;
  bit mon_wr = 0;
  logic [7:0] mon_sh, rd_sh;
  logic [7:0] obs [32], rd_src [32], tx_src [32], rx_got [32];
  int mon_bits, obs_n, lane_err, rd_i, rd_bits, tx_i, tx_n, rx_n, hi_cnt;
  bit tx_en = 0, pend = 0;

  function automatic logic [3:0] mask_of(int w);
    return w == 4 ? 4'b1111 : w == 2 ? 4'b0011 : 4'b0001;
  endfunction

  assign tx_valid = tx_en && tx_i < tx_n;
  assign tx_data  = tx_src[tx_i[4:0]];
  assign io_in    = bw == 4 ? rd_sh[7:4] : bw == 2 ? {2'b0, rd_sh[7:6]} : {2'b0, rd_sh[7], 1'b0};

  always @(posedge sck) begin
    if (mon_wr) begin
      if (io_oe != mask_of(bw)) lane_err++;
      if (bw == 4)      mon_sh = {mon_sh[3:0], io_out};
      else if (bw == 2) mon_sh = {mon_sh[5:0], io_out[1:0]};
      else              mon_sh = {mon_sh[6:0], io_out[0]};
      mon_bits += bw;
      if (mon_bits == 8) begin obs[obs_n] = mon_sh; obs_n++; mon_bits = 0; end
    end else if (io_oe != 4'b0000) lane_err++;
  end

  always @(negedge sck) if (!mon_wr) begin
    rd_sh = rd_sh << bw;
    rd_bits += bw;
    if (rd_bits >= 8) begin rd_bits = 0; rd_i++; rd_sh = rd_src[rd_i]; end
  end

  always @(negedge clk) begin
    if (pend) tx_i++;
    pend = tx_pop;
    if (rx_push) begin rx_got[rx_n] = rx_data; rx_n++; end
    if (sck) hi_cnt++;
  end

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup(input bit dir, input logic [2:0] mode, input int n, input logic [7:0] seed);
    bw = mode == 3'd2 ? 2 : mode == 3'd3 ? 4 : 1;
    mon_wr = dir; mon_bits = 0; obs_n = 0; lane_err = 0; rd_i = 0; rd_bits = 0;
    rx_n = 0; hi_cnt = 0; tx_i = 0; pend = 0; tx_en = 1;
    for (int i = 0; i < 32; i++) begin
      tx_src[i] = seed + 8'(i * 37);
      rd_src[i] = seed + 8'(i * 37);
    end
    tx_n = dir ? n : 0;
    rd_sh = rd_src[0];
  endtask

  task automatic wait_irq();
    for (int k = 0; k < 4000 && !irq; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] cfg_word(bit dir, logic [2:0] mode, bit frag, bit cs);
    return {23'b0, frag, 3'b0, cs, mode, dir};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int hold;
    // R10 reset state
    repeat (3) @(negedge clk);
    check(cs_n == 2'b11, "R10", "cs_n in reset", cs_n, 3);
    check(!sck && io_oe == 0, "R10", "sck/oe in reset", {sck, io_oe}, 0);
    check(!irq, "R10", "irq in reset", irq, 0);
    rd(2'd2, d);
    check(d == 0, "R10", "status in reset", d, 0);
    @(negedge clk) rst_n = 1;

    // R1 configuration readback
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, d);
    check(d == 32'h0000_011F, "R1", "config readback", d, 32'h11F);

    // table walk
    foreach (VEC[v]) begin
      bit dir = VEC[v][21];
      logic [2:0] mode = VEC[v][20:18];
      bit frag = VEC[v][17];
      bit cs = VEC[v][16];
      int n = int'(VEC[v][15:8]);
      int bad = 0;
      logic [1:0] cs_exp = frag ? (cs ? 2'b01 : 2'b10) : 2'b11;
      setup(dir, mode, n, VEC[v][7:0]);
      wr(2'd0, cfg_word(dir, mode, frag, cs));
      wr(2'd1, n);
      wait_irq();
      repeat (2) @(negedge clk);
      for (int i = 0; i < n; i++)
        if ((dir ? obs[i] : rx_got[i]) != tx_src[i]) bad++;
      check(bad == 0 && (dir ? obs_n : rx_n) == n, "R3 R5", "bytes mismatched", bad, 0);
      check(hi_cnt == n * (8 / bw) * 2, "R4", "sck high cycles", hi_cnt, n * (8 / bw) * 2);
      check(irq, "R7", "irq after last byte", irq, 1);
      rd(2'd2, d);
      check(d[16] && !d[0], "R7", "status done/busy", d, 32'h10000);
      check(cs_n == cs_exp, "R8", "chip select after end", cs_n, cs_exp);
      check(lane_err == 0, "R6", "lane enable errors", lane_err, 0);
      check(dir ? rx_n == 0 : tx_i == 0, "R6", "wrong-direction traffic", dir ? rx_n : tx_i, 0);
    end

    // R7 clear by status write
    wr(2'd2, 32'h0001_0000);
    check(!irq, "R7", "irq after clear", irq, 0);

    // R2 zero count
    hi_cnt = 0;
    wr(2'd1, 0);
    repeat (10) @(negedge clk);
    rd(2'd2, d);
    check(irq && d[16] && !d[0], "R2", "zero count status", d, 32'h10000);
    check(hi_cnt == 0 && cs_n == 2'b11, "R2", "zero count clocks", hi_cnt, 0);

    // R11 stall on empty transmit FIFO
    setup(1, 3'd1, 1, 8'h5E);
    tx_en = 0;
    wr(2'd0, cfg_word(1, 3'd1, 0, 0));
    wr(2'd1, 1);
    repeat (30) @(negedge clk);
    rd(2'd2, d);
    check(hi_cnt == 0 && cs_n == 2'b10, "R11", "sck/cs while starved", {hi_cnt[7:0], cs_n}, 2);
    check(d[0] && tx_i == 0, "R11", "busy while starved", d, 1);
    tx_en = 1;
    wait_irq();
    repeat (2) @(negedge clk);
    check(obs_n == 1 && obs[0] == 8'h5E, "R11", "byte after stall", obs[0], 8'h5E);

    // R9 ignored start while busy, mid-transfer
    setup(0, 3'd2, 2, 8'h19);
    wr(2'd0, cfg_word(0, 3'd2, 0, 0));
    wr(2'd1, 2);
    repeat (5) @(negedge clk);
    wr(2'd1, 7);
    wait_irq();
    repeat (20) @(negedge clk);
    rd(2'd2, d);
    check(rx_n == 2 && d[1], "R9", "busy count write ignored", rx_n, 2);
    wr(2'd2, 32'h0000_0002);
    rd(2'd2, d);
    check(!d[1], "R9", "sticky flag clear", d, 0);

    // R9 count write landing on the final completing edge
    setup(1, 3'd3, 1, 8'hC6);
    wr(2'd0, cfg_word(1, 3'd3, 0, 0));
    wr(2'd1, 1);
    repeat (2) @(posedge sck);
    @(negedge clk);
    @(negedge clk);
    reg_valid = 1; reg_write = 1; reg_addr = 2'd1; reg_wdata = 32'd5;
    @(negedge clk);
    reg_valid = 0; reg_write = 0;
    rd(2'd2, d);
    check(d[16] && d[1] && !d[0], "R9", "edge collision status", d, 32'h10002);
    repeat (20) @(negedge clk);
    hold = hi_cnt;
    check(hold == 4 && cs_n == 2'b11, "R9", "no transfer after collision", hold, 4);
    check(obs_n == 1 && obs[0] == 8'hC6, "R5", "collision byte", obs[0], 8'hC6);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule